// File: doc/BRIEF.md
# SECDED-protected simple dual-port RAM

This block is a 512-word by 64-bit memory with one write-only port and one read-only port on a shared clock. Each stored word also holds 8 check bits of an extended Hamming code, which gives single-error correction and double-error detection (SECDED). The 72-bit word lives in an array written so that it maps onto block RAM. Two elaboration parameters turn the check-bit generator and the checker on or off separately. With both on, the block runs as an ordinary protected memory. With only the generator on, it is a plain RAM that also exposes the generated check bits. With only the checker on, the check bits come from outside, so a test can plant any error pattern it likes.

A read fixes a single flipped bit on its way to the output and raises a flag. A read that finds two flipped bits returns the word untouched and raises a different flag. The word in the array is never rewritten. Two write-side controls corrupt fixed data bits of the word being written, so the checker can be exercised in a running system. An optional register adds one cycle to the read path to shorten its timing. The output also carries the address of the word it is presenting.

Top module: `secded_sdp_ram`

## Requirements
- R1: While reset is high and after it is released, rd_data, rd_chk, rd_tag, enc_chk, err_single and err_double are all zero until the first read or write changes them.
- R2: With the generator on (ENC_EN=1), a write stores check bits computed from wr_data and ignores wr_chk. The clock edge that performs the write also places those bits on enc_chk, and they hold there until the next write. Check bits 0 to 6 are the XOR of the codeword positions (1..71, powers of two skipped, data bit 0 at position 3) of the set data bits. Check bit 7 is the parity of the data bits and check bits 0 to 6.
- R3: With the checker on (DEC_EN=1), reading an error-free word returns its data and check bits with both flags low.
- R4: With the checker on, a word with exactly one flipped bit among its 72 stored bits comes out with data and check bits corrected, err_single high and err_double low.
- R5: With the checker on, a word with two flipped bits comes out as stored (no correction), with err_double high and err_single low. The two flags are never high together.
- R6: A correction affects only the output. Reading the same word again reports the same error.
- R7: inj_single on a write flips stored data bit 30. inj_double flips bits 30 and 62. If both are high, bits 30 and 62 are flipped.
- R8: With the checker off (DEC_EN=0), reads return the stored 64 data and 8 check bits unaltered, and both flags stay low.
- R9: With the generator off (ENC_EN=0), the stored check bits are taken from wr_chk, and enc_chk stays zero.
- R10: With OUT_REG=0, data, check bits, flags and tag are valid right after the clock edge that samples rd_en. With OUT_REG=1 they are valid one clock edge later, and all four stay aligned.
- R11: The read outputs hold their values until the next enabled read reaches them. rd_tag carries the address of the word currently on rd_data.
- R12: A read and a write to the same address in the same cycle is not permitted. Reads and writes to different addresses may happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of output state |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_chk | input | CHK_W | External check bits, used only when ENC_EN=0 |
| inj_single | input | 1 | Corrupt data bit 30 of this write |
| inj_double | input | 1 | Corrupt data bits 30 and 62 of this write |
| enc_chk | output | CHK_W | Check bits generated for the latest write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, corrected when possible |
| rd_chk | output | CHK_W | Read check bits, corrected when possible |
| rd_tag | output | ADDR_W | Address of the word on rd_data |
| err_single | output | 1 | A single-bit error was found and corrected |
| err_double | output | 1 | A double-bit error was found |

## Verification
The bound checker watches, on every cycle, that the two error flags are never high together. It also checks that the read outputs and enc_chk move only in the cycles allowed by a read or a write, that rd_tag follows the sampled read address at the configured latency, and that a configuration without the checker never raises a flag. It also flags any attempt to read and write the same address in one cycle. Whether a flipped bit is actually corrected, whether a double error comes out untouched, and where injection lands can only be shown by the bench's scenarios. The bench sweeps every one of the 72 single-bit positions and a set of double-bit pairs in the checker-only configuration and compares the results against its own code model.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of Hamming check bits needed for dw data bits (parity bit excluded).
  function automatic int ham_bits(int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position (1-based) of data bit j; powers of two hold check bits.
  function automatic int data_pos(int j);
    int cnt;
    cnt = 0;
    for (int p = 1; p < 65536; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  typedef enum logic [1:0] {
    RD_CLEAN = 2'd0,
    RD_FIXED = 2'd1,
    RD_FATAL = 2'd2
  } rd_status_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 64,
  localparam int HAM_W = secded_pkg::ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] d,
  output logic [CHK_W-1:0]  chk
);

  logic [HAM_W-1:0] pos_tbl [DATA_W];
  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < DATA_W; j++) begin : g_pos
    localparam int P = secded_pkg::data_pos(j);
    assign pos_tbl[j] = HAM_W'(P);
  end

  // Each Hamming bit covers the data bits whose position has that bit set.
  always_comb begin
    for (int i = 0; i < HAM_W; i++) begin
      ham[i] = 1'b0;
      for (int j = 0; j < DATA_W; j++) begin
        ham[i] = ham[i] ^ (d[j] & pos_tbl[j][i]);
      end
    end
  end

  // Top bit makes the whole codeword even parity.
  assign chk = {(^d) ^ (^ham), ham};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 64,
  localparam int HAM_W = secded_pkg::ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0]       d_in,
  input  logic [CHK_W-1:0]        c_in,
  output logic [DATA_W-1:0]       d_out,
  output logic [CHK_W-1:0]        c_out,
  output secded_pkg::rd_status_e  status
);

  logic [CHK_W-1:0]  c_re;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic [DATA_W-1:0] dflip;
  logic [CHK_W-1:0]  cflip;

  secded_enc #(.DATA_W(DATA_W)) u_re_enc (.d(d_in), .chk(c_re));

  assign syn = c_re[HAM_W-1:0] ^ c_in[HAM_W-1:0];
  assign odd = ^{c_in, d_in};

  // An odd overall parity means one flip; the syndrome names its position.
  for (genvar j = 0; j < DATA_W; j++) begin : g_dfix
    localparam logic [HAM_W-1:0] P = HAM_W'(secded_pkg::data_pos(j));
    assign dflip[j] = odd && (syn == P);
  end

  for (genvar i = 0; i < HAM_W; i++) begin : g_cfix
    localparam logic [HAM_W-1:0] Q = HAM_W'(1 << i);
    assign cflip[i] = odd && (syn == Q);
  end
  assign cflip[HAM_W] = odd && (syn == '0);

  always_comb begin
    if (!odd && syn == '0)               status = secded_pkg::RD_CLEAN;
    else if (odd && ((|dflip) || (|cflip))) status = secded_pkg::RD_FIXED;
    else                                 status = secded_pkg::RD_FATAL;
  end

  assign d_out = d_in ^ dflip;
  assign c_out = c_in ^ cflip;

endmodule

// File: rtl/sdp_mem.sv
module sdp_mem #(
  parameter int WORD_W = 72,
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WORD_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [WORD_W-1:0] rd_q
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // Output latch with synchronous reset, as a block RAM provides.
  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[ra];
  end

endmodule

// File: rtl/secded_sdp_ram.sv
module secded_sdp_ram #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 9,
  parameter bit ENC_EN  = 1'b1,
  parameter bit DEC_EN  = 1'b1,
  parameter bit OUT_REG = 1'b0,
  parameter int INJ_LO  = 30,
  parameter int INJ_HI  = 62,
  localparam int CHK_W  = secded_pkg::ham_bits(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk,
  input  logic              inj_single,
  input  logic              inj_double,
  output logic [CHK_W-1:0]  enc_chk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic [ADDR_W-1:0] rd_tag,
  output logic              err_single,
  output logic              err_double
);

  localparam int WORD_W = DATA_W + CHK_W;

  // ---------------- write side ----------------
  logic [CHK_W-1:0]  gen_chk;
  logic [CHK_W-1:0]  store_chk;
  logic [DATA_W-1:0] inj_mask;

  secded_enc #(.DATA_W(DATA_W)) u_wr_enc (.d(wr_data), .chk(gen_chk));

  always_comb begin
    inj_mask = '0;
    if (inj_single || inj_double) inj_mask[INJ_LO] = 1'b1;
    if (inj_double)               inj_mask[INJ_HI] = 1'b1;
  end

  assign store_chk = ENC_EN ? gen_chk : wr_chk;

  if (ENC_EN) begin : g_par_out
    always_ff @(posedge clk) begin
      if (rst)        enc_chk <= '0;
      else if (wr_en) enc_chk <= gen_chk;
    end
  end else begin : g_no_par_out
    assign enc_chk = '0;
  end

  // ---------------- array ----------------
  logic [WORD_W-1:0] rd_word;

  sdp_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  ({store_chk, wr_data ^ inj_mask}),
    .re  (rd_en),
    .ra  (rd_addr),
    .rd_q(rd_word)
  );

  logic [ADDR_W-1:0] tag_q;
  always_ff @(posedge clk) begin
    if (rst)        tag_q <= '0;
    else if (rd_en) tag_q <= rd_addr;
  end

  // ---------------- read side decode ----------------
  logic [DATA_W-1:0]      dec_data;
  logic [CHK_W-1:0]       dec_chk;
  secded_pkg::rd_status_e dec_st;

  if (DEC_EN) begin : g_dec
    secded_dec #(.DATA_W(DATA_W)) u_dec (
      .d_in  (rd_word[DATA_W-1:0]),
      .c_in  (rd_word[WORD_W-1:DATA_W]),
      .d_out (dec_data),
      .c_out (dec_chk),
      .status(dec_st)
    );
  end else begin : g_raw
    assign dec_data = rd_word[DATA_W-1:0];
    assign dec_chk  = rd_word[WORD_W-1:DATA_W];
    assign dec_st   = secded_pkg::RD_CLEAN;
  end

  // ---------------- output stage ----------------
  if (OUT_REG) begin : g_oreg
    logic fire_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        fire_q     <= 1'b0;
        rd_data    <= '0;
        rd_chk     <= '0;
        rd_tag     <= '0;
        err_single <= 1'b0;
        err_double <= 1'b0;
      end else begin
        fire_q <= rd_en;
        if (fire_q) begin
          rd_data    <= dec_data;
          rd_chk     <= dec_chk;
          rd_tag     <= tag_q;
          err_single <= (dec_st == secded_pkg::RD_FIXED);
          err_double <= (dec_st == secded_pkg::RD_FATAL);
        end
      end
    end
  end else begin : g_olatch
    assign rd_data    = dec_data;
    assign rd_chk     = dec_chk;
    assign rd_tag     = tag_q;
    assign err_single = (dec_st == secded_pkg::RD_FIXED);
    assign err_double = (dec_st == secded_pkg::RD_FATAL);
  end

endmodule

// File: rtl/secded_sdp_ram_chk.sv
module secded_sdp_ram_chk #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 9,
  parameter int CHK_W   = 8,
  parameter bit DEC_EN  = 1'b1,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CHK_W-1:0]  enc_chk,
  input logic [DATA_W-1:0] rd_data,
  input logic [CHK_W-1:0]  rd_tag_chk,
  input logic [ADDR_W-1:0] rd_tag,
  input logic              err_single,
  input logic              err_double
);

  logic rd_d1;
  always_ff @(posedge clk) begin
    if (rst) rd_d1 <= 1'b0;
    else     rd_d1 <= rd_en;
  end

  // R5: the two error flags exclude each other
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(err_single && err_double));

  // R12: no read and write to one address in a cycle
  a_r12_no_collision: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en && (wr_addr == rd_addr)));

  // R2: generated check bits only change on a write
  a_r2_par_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(enc_chk));

  if (DEC_EN == 1'b0) begin : g_quiet
    // R8: no checker, no flags
    a_r8_no_flags: assert property (@(posedge clk) disable iff (rst)
      !err_single && !err_double);
  end

  if (OUT_REG) begin : g_lat_reg
    // R11: outputs hold unless a read reaches them
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !rd_d1 |=> ($stable(rd_data) && $stable(rd_tag_chk) && $stable(rd_tag)));
    // R10: tag follows the read address two edges later
    a_r10_tag_align: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> ##1 (rd_tag == $past(rd_addr, 2)));
  end else begin : g_lat_latch
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> ($stable(rd_data) && $stable(rd_tag_chk) && $stable(rd_tag)));
    a_r10_tag_align: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> (rd_tag == $past(rd_addr)));
  end

endmodule

bind secded_sdp_ram secded_sdp_ram_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .CHK_W  (CHK_W),
  .DEC_EN (DEC_EN),
  .OUT_REG(OUT_REG)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .enc_chk   (enc_chk),
  .rd_data   (rd_data),
  .rd_tag_chk(rd_chk),
  .rd_tag    (rd_tag),
  .err_single(err_single),
  .err_double(err_double)
);

// File: tb/secded_sdp_ram_test.sv
`timescale 1ns/1ps
module secded_sdp_ram_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wr_en = 0, inj_s = 0, inj_d = 0, rd_en = 0;
  logic [8:0]  wr_addr = 0, rd_addr = 0;
  logic [63:0] wr_data = 0;
  logic [7:0]  wr_chk = 0;

  logic [7:0]  u_par, d_par, e_par;
  logic [63:0] u_dat, d_dat, e_dat;
  logic [7:0]  u_chk, d_chk, e_chk;
  logic [8:0]  u_tag, d_tag, e_tag;
  logic        u_se, u_de, d_se, d_de, e_se, e_de;

  secded_sdp_ram #(.ENC_EN(1), .DEC_EN(1), .OUT_REG(0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_chk(wr_chk), .inj_single(inj_s), .inj_double(inj_d), .enc_chk(u_par),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(u_dat), .rd_chk(u_chk),
    .rd_tag(u_tag), .err_single(u_se), .err_double(u_de));

  secded_sdp_ram #(.ENC_EN(0), .DEC_EN(1), .OUT_REG(1)) uut_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_chk(wr_chk), .inj_single(inj_s), .inj_double(inj_d), .enc_chk(d_par),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(d_dat), .rd_chk(d_chk),
    .rd_tag(d_tag), .err_single(d_se), .err_double(d_de));

  secded_sdp_ram #(.ENC_EN(1), .DEC_EN(0), .OUT_REG(0)) uut_enc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_chk(wr_chk), .inj_single(inj_s), .inj_double(inj_d), .enc_chk(e_par),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(e_dat), .rd_chk(e_chk),
    .rd_tag(e_tag), .err_single(e_se), .err_double(e_de));

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [8:0] last_rd = 0;

  // Reference code: XOR of the positions of set data bits, plus overall parity.
  function automatic logic [7:0] ref_chk(logic [63:0] d);
    int idx;
    logic [6:0] acc;
    idx = 0;
    acc = '0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[idx]) acc = acc ^ 7'(p);
        idx++;
      end
    end
    return {(^d) ^ (^acc), acc};
  endfunction

  function automatic logic [63:0] pat(int k);
    return (64'h0F1E_2D3C_4B5A_6978 * 64'(k + 1)) ^ {32'(k), 32'(k * 7)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [63:0] d, input logic [7:0] c,
                    input bit si, input bit di);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_chk = c; inj_s = si; inj_d = di;
    @(negedge clk);
    wr_en = 0; inj_s = 0; inj_d = 0;
  endtask

  // Latch-mode outputs are valid at the first negedge, the registered one at the second.
  task automatic rd(input logic [8:0] a);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    check(u_tag == a, "R10 latch tag", 72'(u_tag), 72'(a));
    check(d_tag == last_rd, "R10 reg still old", 72'(d_tag), 72'(last_rd));
    @(negedge clk);
    check(d_tag == a, "R10 reg tag", 72'(d_tag), 72'(a));
    last_rd = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(u_dat == 0 && u_chk == 0 && u_tag == 0 && !u_se && !u_de && u_par == 0,
          "R1 reset std", {u_chk, u_dat}, 72'd0);
    check(d_dat == 0 && d_chk == 0 && !d_se && !d_de, "R1 reset reg", {d_chk, d_dat}, 72'd0);
    rst = 0;
    @(negedge clk);
    check(u_dat == 0 && u_tag == 0 && u_par == 0 && d_tag == 0, "R1 after release",
          {u_chk, u_dat}, 72'd0);

    // R2/R3/R8: clean words, external check bits deliberately wrong
    for (int a = 0; a < 16; a++) begin
      logic [63:0] d;
      d = (a == 14) ? 64'd0 : (a == 15) ? '1 : pat(a);
      wr(9'(a), d, ref_chk(d) ^ 8'hA5, 0, 0);
      check(u_par == ref_chk(d), "R2 enc_chk", 72'(u_par), 72'(ref_chk(d)));
    end
    check(d_par == 0, "R9 enc_chk zero", 72'(d_par), 72'd0);
    for (int a = 0; a < 16; a++) begin
      logic [63:0] d;
      d = (a == 14) ? 64'd0 : (a == 15) ? '1 : pat(a);
      rd(9'(a));
      check(u_dat == d && !u_se && !u_de, "R3 clean read", {6'd0, u_se, u_de, u_dat}, 72'(d));
      check(u_chk == ref_chk(d), "R2 stored chk", 72'(u_chk), 72'(ref_chk(d)));
      check(u_tag == 9'(a), "R11 tag", 72'(u_tag), 72'(a));
      check(e_dat == d && e_chk == ref_chk(d) && !e_se && !e_de, "R8 raw read",
            {e_chk, e_dat}, {ref_chk(d), d});
    end

    // R11: outputs hold across idle cycles and unrelated writes
    wr(9'd40, 64'h1234, 8'h00, 0, 0);
    repeat (3) @(negedge clk);
    check(u_dat == '1 && u_tag == 9'd15, "R11 hold data", 72'(u_dat), 72'({64{1'b1}}));
    check(d_dat == '1 && d_tag == 9'd15, "R11 hold reg", 72'(d_dat), 72'({64{1'b1}}));

    // R7: injection on write
    begin
      logic [63:0] d;
      d = 64'hDEAD_BEEF_0BAD_F00D;
      wr(9'd20, d, 8'h00, 1, 0);
      wr(9'd21, d, 8'h00, 0, 1);
      wr(9'd22, d, 8'h00, 1, 1);
      rd(9'd20);
      check(u_dat == d && u_se && !u_de, "R7 R4 single inject", {6'd0, u_se, u_de, u_dat}, {8'h2, d});
      check(e_dat == (d ^ (64'd1 << 30)), "R7 bit30 stored", 72'(e_dat), 72'(d ^ (64'd1 << 30)));
      rd(9'd21);
      check(u_dat == (d ^ (64'd1 << 30) ^ (64'd1 << 62)) && !u_se && u_de, "R7 R5 double inject",
            {6'd0, u_se, u_de, u_dat}, {8'h1, d ^ (64'd1 << 30) ^ (64'd1 << 62)});
      check(u_chk == ref_chk(d), "R5 raw chk", 72'(u_chk), 72'(ref_chk(d)));
      rd(9'd22);
      check(e_dat == (d ^ (64'd1 << 30) ^ (64'd1 << 62)), "R7 both gives double",
            72'(e_dat), 72'(d ^ (64'd1 << 30) ^ (64'd1 << 62)));
      check(u_de && !u_se, "R7 both flags", {70'd0, u_se, u_de}, 72'd1);
      rd(9'd20);
      check(u_se && u_dat == d, "R6 no scrub", {7'd0, u_se, u_dat}, {8'h1, d});
    end

    // R4/R9: every single-bit position through external check bits
    for (int k = 0; k < 72; k++) begin
      logic [63:0] d;
      logic [63:0] wd;
      logic [7:0]  wc;
      d  = pat(k + 40);
      wd = (k < 64) ? d ^ (64'd1 << k) : d;
      wc = (k >= 64) ? ref_chk(d) ^ (8'd1 << (k - 64)) : ref_chk(d);
      wr(9'(100 + k), wd, wc, 0, 0);
      rd(9'(100 + k));
      check(d_dat == d && d_chk == ref_chk(d) && d_se && !d_de, "R4 R9 single sweep",
            {d_chk, d_dat}, {ref_chk(d), d});
    end

    // R5: double-bit pairs are reported and not altered
    for (int i = 0; i < 12; i++) begin
      logic [71:0] cw;
      int k1;
      int k2;
      logic [63:0] d;
      k1 = i * 6;
      k2 = (k1 + 29) % 72;
      d  = pat(i + 200);
      cw = {ref_chk(d), d};
      cw[k1] = ~cw[k1];
      cw[k2] = ~cw[k2];
      wr(9'(300 + i), cw[63:0], cw[71:64], 0, 0);
      rd(9'(300 + i));
      check({d_chk, d_dat} == cw && d_de && !d_se, "R5 double sweep", {d_chk, d_dat}, cw);
    end

    // R9: correct external bits read clean
    begin
      logic [63:0] d;
      d = pat(77);
      wr(9'd400, d, ref_chk(d), 0, 0);
      rd(9'd400);
      check(d_dat == d && !d_se && !d_de, "R9 clean external", {6'd0, d_se, d_de, d_dat}, 72'(d));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule